// File: doc/BRIEF.md
# Parallel-to-Serial Transmit Shifter with Line Forcing and Loopback

This block turns 10-bit transmit characters into a serial bit stream. A character is taken in on each byte strobe, which marks a rising edge of the byte clock. The character then passes through a small elastic word buffer and is shifted out least significant bit first, one bit per bit strobe. The bit strobe runs at exactly ten times the byte rate, and words follow each other with no idle bits between them.

The serial output is a complementary pair. Three conditions force it to static levels:
- While the transmit PLL has not reported lock, the pair is held positive-low / negative-high.
- While transmit reset is asserted, the pair is held at the same levels.
- In wrap (loopback) mode, both lines are held high. The live stream then appears on a separate loopback output that feeds the receive side.

Each time the block leaves a forced-idle state, the word buffer restarts half full with cleared entries. This gives a fixed, known delay from capture to transmission. All logic runs on one clock, and the two strobes act as clock enables.

Top module: `sertx_top`

## Requirements
- R1: A word is latched on a cycle with `byte_stb` high and later sent bit 0 first, one bit per cycle with `bit_stb` high. Ten strobes make one word, with no gap between consecutive words.
- R2: Running starts on the first clock edge where `pll_lock`=1 and `tx_rst`=0. From that edge the first two words on the line are all zero. The word latched on the k-th byte strobe after the start (k=0,1,...) is the (k+2)-th word sent.
- R3: A cycle with `bit_stb` low and `byte_stb` low changes neither the serial output nor the stream position.
- R4: While running with wrap off, `ser_n` is always the complement of `ser_p`.
- R5: While `pll_lock` is low, `ser_p`=0 and `ser_n`=1, whatever the strobes and data do.
- R6: While `tx_rst` is high, `ser_p`=0 and `ser_n`=1 and `lpbk_ser`=0, even if `wrap_en` is high.
- R7: While running with `wrap_en` high, `ser_p`=1 and `ser_n`=1, and `lpbk_ser` carries the serial stream. Whenever wrap is off or the block is not running, `lpbk_ser` is 0.
- R8: With one byte strobe per ten bit strobes, the buffer is never read while empty and never written while full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; both strobes are enables on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_stb | input | 1 | Byte-clock rising-edge marker; latches `tx_word` |
| bit_stb | input | 1 | Bit-rate enable, ten per byte strobe |
| tx_word | input | 10 | Transmit character, bit 0 sent first |
| pll_lock | input | 1 | Transmit PLL locked flag |
| tx_rst | input | 1 | Transmit reset, active high |
| wrap_en | input | 1 | Loopback enable |
| ser_p | output | 1 | Positive serial line |
| ser_n | output | 1 | Negative serial line |
| lpbk_ser | output | 1 | Serial stream routed to the receive side in wrap mode |

## Verification
The bench concentrates on a few corner cases.

The two stale words at the start of a run are checked as zeros, and every later word is checked at its exact stream position. A buffer that does not restart half full, or whose entries are not cleared, shifts or corrupts the whole stream.

Stall cycles are inserted in the middle of words. A shifter that advances without a strobe drops or duplicates bits.

Transmit reset is applied with wrap active, which catches a wrong priority that would drive both lines high. A second run after the reset checks that the loopback output carries the same stream while both line outputs stay high.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Line drive selection, in priority order: idle wins over wrap.
  typedef enum logic [1:0] {
    LINE_IDLE = 2'd0,
    LINE_DATA = 2'd1,
    LINE_WRAP = 2'd2
  } line_mode_e;

  function automatic line_mode_e pick_mode(input logic running, input logic wrap);
    if (!running)  return LINE_IDLE;
    else if (wrap) return LINE_WRAP;
    else           return LINE_DATA;
  endfunction

  // Returns {positive, negative} line levels for a mode and data bit.
  function automatic logic [1:0] line_levels(input line_mode_e m, input logic b);
    case (m)
      LINE_DATA: return {b, ~b};
      LINE_WRAP: return 2'b11;
      default:   return 2'b01;
    endcase
  endfunction

  // Buffer fill from pointers that carry one extra wrap bit.
  function automatic int unsigned fill_level(input int unsigned wr, input int unsigned rd,
                                             input int unsigned pw);
    return (wr - rd) & ((1 << (pw + 1)) - 1);
  endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int WORD_W = 10,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data
);
  import sertx_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] WR_START = PW'(DEPTH / 2);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW:0] wr_ptr, rd_ptr;
  logic [PW:0] fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= WR_START;
      rd_ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (hold) begin
      wr_ptr <= WR_START;
      rd_ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wr_en) begin
        mem[wr_ptr[PW-1:0]] <= wr_data;
        wr_ptr <= wr_ptr + 1'b1;
      end
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign rd_data = mem[rd_ptr[PW-1:0]];
  assign fill    = (PW+1)'(fill_level(int'(wr_ptr), int'(rd_ptr), PW));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hold) |-> (fill != '0));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hold && !rd_en) |-> (fill != (PW+1)'(DEPTH)));

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              bit_stb,
  input  logic [WORD_W-1:0] load_data,
  output logic              load_fire,
  output logic              ser_bit
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [CW-1:0]     bit_idx;

  assign load_fire = bit_stb && !hold && (bit_idx == LAST);
  assign ser_bit   = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_idx <= LAST;
    end else if (hold) begin
      shreg   <= '0;
      bit_idx <= LAST;
    end else if (load_fire) begin
      shreg   <= load_data;
      bit_idx <= '0;
    end else if (bit_stb) begin
      shreg   <= shreg >> 1;
      bit_idx <= bit_idx + 1'b1;
    end
  end

  // R3
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && !hold) |=> $stable(ser_bit));
  // R1
  word_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && !hold) |=> (ser_bit == $past(load_data[0])));

endmodule

// File: rtl/sertx_drive.sv
module sertx_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic wrap,
  input  logic data_bit,
  output logic line_p,
  output logic line_n,
  output logic loop_bit
);
  import sertx_pkg::*;

  line_mode_e mode;
  logic [1:0] lv;

  assign mode     = pick_mode(running, wrap);
  assign lv       = line_levels(mode, data_bit);
  assign line_p   = lv[1];
  assign line_n   = lv[0];
  assign loop_bit = (mode == LINE_WRAP) ? data_bit : 1'b0;

  // R4
  compl_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !wrap) |-> (line_n != line_p));
  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!line_p && line_n && !loop_bit));
  // R7
  wrap_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wrap) |-> (line_p && line_n));

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int WORD_W = 10,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic              bit_stb,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              pll_lock,
  input  logic              tx_rst,
  input  logic              wrap_en,
  output logic              ser_p,
  output logic              ser_n,
  output logic              lpbk_ser
);
  logic              hold;
  logic              running;
  logic [WORD_W-1:0] cap_q;
  logic              cap_new;
  logic              wr_en;
  logic [WORD_W-1:0] head;
  logic              load_fire;
  logic              ser_bit;

  assign hold    = !pll_lock || tx_rst;
  assign running = rst_n && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      cap_new <= 1'b0;
    end else begin
      if (byte_stb) cap_q <= tx_word;
      cap_new <= byte_stb && !hold;
    end
  end

  assign wr_en = cap_new && !hold;

  sertx_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .wr_en(wr_en), .wr_data(cap_q),
    .rd_en(load_fire), .rd_data(head)
  );

  sertx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .hold(hold), .bit_stb(bit_stb),
    .load_data(head), .load_fire(load_fire), .ser_bit(ser_bit)
  );

  sertx_drive u_drv (
    .clk(clk), .rst_n(rst_n), .running(running), .wrap(wrap_en),
    .data_bit(ser_bit), .line_p(ser_p), .line_n(ser_n), .loop_bit(lpbk_ser)
  );

  // R6
  txrst_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |-> (!ser_p && ser_n && !lpbk_ser));

endmodule

// File: tb/sertx_top_test.sv
module sertx_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int MAXB = 128;

  typedef struct packed { logic [9:0] w; logic [3:0] stalls; } vec_t;
  localparam vec_t TBL [NW] = '{
    '{10'h17C, 4'd0}, '{10'h283, 4'd2}, '{10'h3FF, 4'd0}, '{10'h000, 4'd3},
    '{10'h155, 4'd1}, '{10'h2AA, 4'd0}, '{10'h001, 4'd4}, '{10'h200, 4'd0}
  };

  logic clk = 0, rst_n = 0, byte_stb = 0, bit_stb = 0;
  logic [9:0] tx_word = '0;
  logic pll_lock = 0, tx_rst = 0, wrap_en = 0;
  logic ser_p, ser_n, lpbk_ser;

  int checks = 0, errors = 0;
  int nbit = 0, bcnt = 0;
  int bad_pair = 0;
  logic use_wrap = 0;
  logic stream [MAXB];

  always #(CLK_PERIOD/2) clk = ~clk;

  sertx_top uut (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .bit_stb(bit_stb),
    .tx_word(tx_word), .pll_lock(pll_lock), .tx_rst(tx_rst), .wrap_en(wrap_en),
    .ser_p(ser_p), .ser_n(ser_n), .lpbk_ser(lpbk_ser)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, let the edge pass, sample at next negedge.
  task automatic step(input logic s);
    bit_stb  = s;
    byte_stb = s && (bcnt % 10 == 3);
    @(posedge clk);
    @(negedge clk);
    bit_stb  = 0;
    byte_stb = 0;
    if (s) begin
      if (nbit < MAXB) stream[nbit] = use_wrap ? lpbk_ser : ser_p;
      if (use_wrap) begin
        if (!(ser_p && ser_n)) bad_pair++;
      end else begin
        if (ser_n == ser_p) bad_pair++;
      end
      nbit++;
      bcnt++;
    end
  endtask

  function automatic logic [9:0] word_at(input int k);
    logic [9:0] v;
    for (int b = 0; b < 10; b++) v[b] = stream[10*k + b];
    return v;
  endfunction

  task automatic run_seq(input logic w);
    logic held_p, held_n;
    use_wrap = w; nbit = 0; bcnt = 0; bad_pair = 0;
    wrap_en = w; tx_rst = 0; pll_lock = 1;
    for (int k = 0; k < NW; k++) begin
      tx_word = TBL[k].w;
      for (int j = 0; j < 10; j++) begin
        if (j == 5) begin
          for (int s = 0; s < int'(TBL[k].stalls); s++) begin
            held_p = ser_p; held_n = ser_n;
            step(1'b0);
            // R3: a stall changes nothing on the line
            chk(ser_p == held_p && ser_n == held_n, "R3 stall", {ser_p, ser_n}, {held_p, held_n});
          end
        end
        step(1'b1);
      end
    end
    tx_word = '0;
    for (int j = 0; j < 30; j++) step(1'b1);
    // R2: two cleared words lead each run
    chk(word_at(0) == 10'h000, "R2 lead0", word_at(0), 0);
    chk(word_at(1) == 10'h000, "R2 lead1", word_at(1), 0);
    // R1: each word appears LSB first at its fixed slot
    for (int k = 0; k < NW; k++)
      chk(word_at(k + 2) == TBL[k].w, w ? "R7 loop word" : "R1 word",
          word_at(k + 2), TBL[k].w);
    if (w) chk(bad_pair == 0, "R7 both high", bad_pair, 0);
    else   chk(bad_pair == 0, "R4 complement", bad_pair, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R5: reset state, no lock
    chk(!ser_p && ser_n && !lpbk_ser, "R5 reset", {ser_p, ser_n, lpbk_ser}, 3'b010);
    rst_n = 1;
    tx_word = 10'h3FF;
    for (int i = 0; i < 25; i++) step(1'b1);
    // R5: strobing without lock keeps the idle levels
    chk(!ser_p && ser_n, "R5 no lock", {ser_p, ser_n}, 2'b01);

    run_seq(1'b0);

    tx_rst = 1; wrap_en = 1; tx_word = 10'h3FF;
    for (int i = 0; i < 15; i++) step(1'b1);
    // R6: transmit reset beats wrap
    chk(!ser_p && ser_n && !lpbk_ser, "R6 tx reset", {ser_p, ser_n, lpbk_ser}, 3'b010);

    run_seq(1'b1);

    wrap_en = 0;
    for (int i = 0; i < 3; i++) step(1'b1);
    // R7: loopback output idle when wrap is off
    chk(lpbk_ser == 1'b0, "R7 loop idle", lpbk_ser, 0);

    pll_lock = 0; wrap_en = 1;
    for (int i = 0; i < 12; i++) step(1'b1);
    // R5: lock loss with wrap requested still forces idle
    chk(!ser_p && ser_n && !lpbk_ser, "R5 lock lost", {ser_p, ser_n, lpbk_ser}, 3'b010);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule